// File: doc/BRIEF.md
# Multi-Cycle Unpipelined Processor Core

This block runs a small load/store instruction set one instruction at a time. It steps each instruction through a sequence of phases: fetch, decode with register read, execute, memory access and write-back. Only the phases that an instruction class needs are visited, so a branch takes three cycles, a register operation four and a load five. Internal registers carry results from one phase to the next. These are the program counter, the instruction register, two operand latches and an ALU result latch.

The core drives two separate synchronous memory ports, one for instructions and one for data. Each port returns read data in the cycle after its read strobe. A data write takes effect on the rising edge of the cycle that carries the write strobe. The core raises `retire` for the last cycle of every instruction, and the next instruction's fetch follows immediately. Instruction fields sit at fixed positions: opcode [31:26], first source [25:21], second source or immediate destination [20:16], register destination [15:11], function code [5:0], immediate [15:0] and jump target [25:0]. Register 0 always reads as zero.

Top module: `mc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `imem_ren` is 1, `imem_addr` equals RESET_PC (default 0), and `retire`, `dmem_ren` and `dmem_wen` are 0. Every general register reads as 0 after reset.
- R2: Every instruction starts with one fetch cycle that presents the PC on `imem_addr` with `imem_ren` high. The next cycle is a decode cycle in which no strobe is raised and `retire` stays low.
- R3: Opcode 0 selects a register operation by function code: 0x21 add, 0x23 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than. The result goes to the register in [15:11] and the instruction retires in its 4th cycle. Register 0 reads as zero, and a write to it is discarded.
- R4: The immediate operations retire in their 4th cycle and write the register in [20:16]. Opcode 0x09 adds the sign-extended immediate. Opcode 0x0D ORs in the zero-extended immediate. Opcode 0x0F loads the immediate shifted left by 16.
- R5: A load (opcode 0x23) raises `dmem_ren` in its 4th cycle, with address = first source + sign-extended immediate. It writes the data returned in the next cycle into the register in [20:16] and retires in that 5th cycle.
- R6: A store (opcode 0x2B) raises `dmem_wen` in its 4th cycle. The address is formed as in R5 and the data is the register in [20:16]. The store retires in that same cycle.
- R7: A conditional branch (opcode 0x04) retires in its 3rd cycle. If the first source register is zero, the next PC is PC+4+sign-extended offset×4. Otherwise the next PC is PC+4.
- R8: Jumps retire in their 3rd cycle. Opcode 0x02 jumps to {PC+4 bits [31:28], target, 00}. Opcode 0x03 does the same and also writes PC+4 into register 31. Opcode 0x06 jumps to the first source register. Opcode 0x07 does the same and also writes PC+4 into register 31.
- R9: An unrecognised opcode, or an opcode-0 instruction with an unlisted function code, retires in its 3rd cycle. It changes no register and no memory, and the next PC is PC+4.
- R10: `retire` is high for exactly one cycle. The cycle after it is always the fetch of the next instruction, at the updated PC.
- R11: At most one of `imem_ren`, `dmem_ren` and `dmem_wen` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_ren | output | 1 | Instruction read strobe, high in fetch cycles |
| imem_addr | output | XLEN | Byte address of the instruction to fetch (the PC) |
| imem_rdata | input | XLEN | Instruction word, valid the cycle after `imem_ren` |
| dmem_ren | output | 1 | Data read strobe for loads |
| dmem_wen | output | 1 | Data write strobe for stores |
| dmem_addr | output | XLEN | Data byte address |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data, valid the cycle after `dmem_ren` |
| retire | output | 1 | High in the final cycle of each instruction |

## Verification
The assertions assume two things about the memories. Each one returns valid data exactly one cycle after its read strobe, and fetched words never arrive at any other time. They also assume that instruction addresses stay word aligned. The bench models both memories as arrays that register their read data on the strobed edge. Every program uses only aligned addresses. The memory words after each program are filled with unrecognised opcodes, so any fetch beyond a program retires harmlessly until reset is applied again.

// File: rtl/mc_pkg.sv
package mc_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int INSN_W = 32;
   localparam int RIDX_W = 5;

   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_J     = 6'h02;
   localparam logic [5:0] OPC_JAL   = 6'h03;
   localparam logic [5:0] OPC_BEQZ  = 6'h04;
   localparam logic [5:0] OPC_JR    = 6'h06;
   localparam logic [5:0] OPC_JALR  = 6'h07;
   localparam logic [5:0] OPC_ADDI  = 6'h09;
   localparam logic [5:0] OPC_ORI   = 6'h0D;
   localparam logic [5:0] OPC_LUI   = 6'h0F;
   localparam logic [5:0] OPC_LW    = 6'h23;
   localparam logic [5:0] OPC_SW    = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h21;
   localparam logic [5:0] FN_SUB = 6'h23;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_XOR = 6'h26;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {PH_FETCH, PH_DECODE, PH_EXEC, PH_MEM, PH_WB} phase_e;
   typedef enum logic [2:0] {IC_REG, IC_IMM, IC_LOAD, IC_STORE, IC_FLOW, IC_NONE} iclass_e;
   typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_PASSB} alu_op_e;
   typedef enum logic [1:0] {PCS_SEQ, PCS_BR, PCS_RIND, PCS_JABS} pcsel_e;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int AW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   ra_a,
   input  logic [AW-1:0]   ra_b,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] rd_a,
   output logic [XLEN-1:0] rd_b
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [NREG*XLEN-1:0] flat;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         if (g == 0) begin : g_zero
            assign flat[XLEN-1:0] = '0;
         end else begin : g_live
            logic [XLEN-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (we && wa == AW'(g))
                  q <= wd;
            end
            assign flat[g*XLEN +: XLEN] = q;
         end
      end
   endgenerate

   assign rd_a = flat[ra_a*XLEN +: XLEN];
   assign rd_b = flat[ra_b*XLEN +: XLEN];

   // R3: register 0 must read as zero whatever was written to it
   p_zero_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_a == '0) |-> (rd_a == '0));
endmodule

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; #(
   parameter int XLEN = 32
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);
   timeunit 1ns;
   timeprecision 100ps;

   always_comb begin
      case (op)
         ALU_SUB:   y = a - b;
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_XOR:   y = a ^ b;
         ALU_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
         ALU_PASSB: y = b;
         default:   y = a + b;
      endcase
   end
endmodule

// File: rtl/mc_decode.sv
module mc_decode import mc_pkg::*; #(
   parameter int XLEN = 32
) (
   input  logic [5:0]        opc,
   input  logic [RIDX_W-1:0] rt,
   input  logic [15:0]       imm16,
   output iclass_e           iclass,
   output alu_op_e           alu_op,
   output logic              use_imm,
   output logic              link,
   output logic [RIDX_W-1:0] dst,
   output pcsel_e            pcs,
   output logic [XLEN-1:0]   imm_x
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [XLEN-1:0] sext, zext, high;
   assign sext = {{(XLEN-16){imm16[15]}}, imm16};
   assign zext = {{(XLEN-16){1'b0}}, imm16};
   assign high = {imm16, {(XLEN-16){1'b0}}};

   always_comb begin
      iclass  = IC_NONE;
      alu_op  = ALU_ADD;
      use_imm = 1'b0;
      link    = 1'b0;
      dst     = rt;
      pcs     = PCS_SEQ;
      imm_x   = sext;
      case (opc)
         OPC_RTYPE: begin
            iclass = IC_REG;
            dst    = imm16[15:11];
            case (imm16[5:0])
               FN_ADD:  alu_op = ALU_ADD;
               FN_SUB:  alu_op = ALU_SUB;
               FN_AND:  alu_op = ALU_AND;
               FN_OR:   alu_op = ALU_OR;
               FN_XOR:  alu_op = ALU_XOR;
               FN_SLT:  alu_op = ALU_SLT;
               default: iclass = IC_NONE;
            endcase
         end
         OPC_ADDI: begin iclass = IC_IMM; use_imm = 1'b1; end
         OPC_ORI:  begin iclass = IC_IMM; use_imm = 1'b1; alu_op = ALU_OR; imm_x = zext; end
         OPC_LUI:  begin iclass = IC_IMM; use_imm = 1'b1; alu_op = ALU_PASSB; imm_x = high; end
         OPC_LW:   begin iclass = IC_LOAD; use_imm = 1'b1; end
         OPC_SW:   begin iclass = IC_STORE; use_imm = 1'b1; end
         OPC_BEQZ: begin iclass = IC_FLOW; pcs = PCS_BR; end
         OPC_J:    begin iclass = IC_FLOW; pcs = PCS_JABS; end
         OPC_JAL:  begin iclass = IC_FLOW; pcs = PCS_JABS; link = 1'b1; end
         OPC_JR:   begin iclass = IC_FLOW; pcs = PCS_RIND; end
         OPC_JALR: begin iclass = IC_FLOW; pcs = PCS_RIND; link = 1'b1; end
         default:  iclass = IC_NONE;
      endcase
   end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
   input  logic    clk,
   input  logic    rst_n,
   input  iclass_e iclass,
   output phase_e  phase,
   output logic    retire
);
   timeunit 1ns;
   timeprecision 100ps;

   phase_e nxt;

   always_comb begin
      nxt    = phase;
      retire = 1'b0;
      case (phase)
         PH_FETCH:  nxt = PH_DECODE;
         PH_DECODE: nxt = PH_EXEC;
         PH_EXEC: begin
            case (iclass)
               IC_LOAD, IC_STORE: nxt = PH_MEM;
               IC_REG, IC_IMM:    nxt = PH_WB;
               default: begin nxt = PH_FETCH; retire = 1'b1; end
            endcase
         end
         PH_MEM: begin
            if (iclass == IC_STORE) begin
               nxt    = PH_FETCH;
               retire = 1'b1;
            end else begin
               nxt = PH_WB;
            end
         end
         PH_WB:   begin nxt = PH_FETCH; retire = 1'b1; end
         default: nxt = PH_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_FETCH;
      else        phase <= nxt;
   end

   // R10: completion is a single-cycle pulse
   p_retire_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> !retire);
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
   parameter int          XLEN     = 32,
   parameter int          NREG     = 32,
   parameter int          LINK_REG = 31,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic            imem_ren,
   output logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_rdata,
   output logic            dmem_ren,
   output logic            dmem_wen,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            retire
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int RAW = $clog2(NREG);

   generate
      if (XLEN != INSN_W) begin : g_bad_xlen
         $error("mc_core: XLEN must equal the instruction width");
      end
      if (RAW != RIDX_W) begin : g_bad_nreg
         $error("mc_core: NREG must match the register field width");
      end
      if (LINK_REG < 1 || LINK_REG >= NREG) begin : g_bad_link
         $error("mc_core: LINK_REG out of range");
      end
   endgenerate

   phase_e          phase;
   iclass_e         icls;
   alu_op_e         aop;
   pcsel_e          pcs;
   logic            use_imm, link;
   logic [RAW-1:0]  dst;
   logic [XLEN-1:0] imm_x;
   logic [XLEN-1:0] pc_q, ir_q, opa_q, opb_q, alu_q;
   logic [XLEN-1:0] rf_a, rf_b, alu_y, alu_b;
   logic [XLEN-1:0] pc_seq, pc_br, pc_jabs, pc_next;
   logic            rf_we;
   logic [RAW-1:0]  rf_wa;
   logic [XLEN-1:0] rf_wd;

   mc_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .iclass(icls), .phase(phase), .retire(retire)
   );

   mc_decode #(.XLEN(XLEN)) u_dec (
      .opc(ir_q[31:26]), .rt(ir_q[20:16]), .imm16(ir_q[15:0]),
      .iclass(icls), .alu_op(aop), .use_imm(use_imm), .link(link),
      .dst(dst), .pcs(pcs), .imm_x(imm_x)
   );

   mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra_a(imem_rdata[25:21]), .ra_b(imem_rdata[20:16]),
      .we(rf_we), .wa(rf_wa), .wd(rf_wd),
      .rd_a(rf_a), .rd_b(rf_b)
   );

   assign alu_b = use_imm ? imm_x : opb_q;

   mc_alu #(.XLEN(XLEN)) u_alu (
      .op(aop), .a(opa_q), .b(alu_b), .y(alu_y)
   );

   // next-PC selection, applied only on the retiring cycle
   assign pc_seq  = pc_q + XLEN'(4);
   assign pc_br   = pc_seq + {imm_x[XLEN-3:0], 2'b00};
   assign pc_jabs = {pc_seq[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

   always_comb begin
      pc_next = pc_seq;
      if (phase == PH_EXEC && icls == IC_FLOW) begin
         case (pcs)
            PCS_BR:   pc_next = (opa_q == '0) ? pc_br : pc_seq;
            PCS_RIND: pc_next = opa_q;
            PCS_JABS: pc_next = pc_jabs;
            default:  pc_next = pc_seq;
         endcase
      end
   end

   // register write: link in execute, results in write-back
   assign rf_we = (phase == PH_WB) || (phase == PH_EXEC && link);
   assign rf_wa = (phase == PH_EXEC) ? RAW'(LINK_REG) : dst;
   assign rf_wd = (phase == PH_EXEC) ? pc_seq :
                  (icls == IC_LOAD)  ? dmem_rdata : alu_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         ir_q  <= '0;
         opa_q <= '0;
         opb_q <= '0;
         alu_q <= '0;
      end else begin
         if (phase == PH_DECODE) begin
            ir_q  <= imem_rdata;
            opa_q <= rf_a;
            opb_q <= rf_b;
         end
         if (phase == PH_EXEC) alu_q <= alu_y;
         if (retire)           pc_q  <= pc_next;
      end
   end

   assign imem_ren   = (phase == PH_FETCH);
   assign imem_addr  = pc_q;
   assign dmem_ren   = (phase == PH_MEM) && (icls == IC_LOAD);
   assign dmem_wen   = (phase == PH_MEM) && (icls == IC_STORE);
   assign dmem_addr  = alu_q;
   assign dmem_wdata = opb_q;

   // R2: the cycle after a fetch is a quiet decode cycle
   p_decode_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      imem_ren |=> !(imem_ren || retire || dmem_ren || dmem_wen));
   // R5: load data is written back in the cycle after the read strobe
   p_load_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_ren |=> (retire && !dmem_ren && !dmem_wen));
   // R6: a store retires in its memory cycle
   p_store_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_wen |-> retire);
   // R10: completion is followed directly by a fetch
   p_fetch_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> imem_ren);
   // R11: memory strobes never overlap
   p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({imem_ren, dmem_ren, dmem_wen}));
endmodule

// File: tb/mc_core_tb.sv
module mc_core_tb;
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [5:0] T_RT = 6'h00, T_J = 6'h02, T_JAL = 6'h03, T_BEQZ = 6'h04;
   localparam logic [5:0] T_JR = 6'h06, T_JALR = 6'h07, T_ADDI = 6'h09, T_ORI = 6'h0D;
   localparam logic [5:0] T_LUI = 6'h0F, T_LW = 6'h23, T_SW = 6'h2B, T_BAD = 6'h3F;
   localparam logic [5:0] F_ADD = 6'h21, F_SUB = 6'h23, F_AND = 6'h24, F_XOR = 6'h26;
   localparam logic [5:0] F_SLT = 6'h2A, F_BAD = 6'h3E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        imem_ren, dmem_ren, dmem_wen, retire;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;

   logic [31:0] imem [64];
   logic [31:0] dmem [64];

   int nchk = 0, nfail = 0;
   int nret, nfetch, cyc, r10_bad, r11_bad;
   logic prev_ret;
   int lens [32];
   logic [31:0] fpc [32];

   always #2.5 clk = ~clk;

   mc_core u_dut (
      .clk(clk), .rst_n(rst_n),
      .imem_ren(imem_ren), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_ren(dmem_ren), .dmem_wen(dmem_wen), .dmem_addr(dmem_addr),
      .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .retire(retire)
   );

   initial imem_rdata = '0;
   initial dmem_rdata = '0;

   always @(posedge clk) begin
      if (imem_ren) imem_rdata <= imem[imem_addr[7:2]];
      if (dmem_ren) dmem_rdata <= dmem[dmem_addr[7:2]];
      if (dmem_wen) dmem[dmem_addr[7:2]] = dmem_wdata;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (imem_ren && nfetch < 32) fpc[nfetch] = imem_addr;
         if (imem_ren) nfetch++;
         if (prev_ret && !imem_ren) r10_bad++;
         if ($countones({imem_ren, dmem_ren, dmem_wen}) > 1) r11_bad++;
         cyc++;
         if (retire) begin
            if (nret < 32) lens[nret] = cyc;
            nret++;
            cyc = 0;
         end
         prev_ret = retire;
      end
   end

   function automatic logic [31:0] e_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
      return {T_RT, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] e_i(input logic [5:0] op, input int rs, input int rt, input int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction
   function automatic logic [31:0] e_j(input logic [5:0] op, input int tgt);
      return {op, 26'(tgt)};
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 64; i++) begin
         imem[i] = {T_BAD, 26'd0};
         dmem[i] = 32'hDEADBEEF;
      end
   endtask

   task automatic start();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      nret = 0; nfetch = 0; cyc = 0; r10_bad = 0; r11_bad = 0; prev_ret = 1'b0;
      @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic run(input int n);
      int guard;
      start();
      guard = 0;
      while (nret < n && guard < 400) begin
         @(posedge clk);
         guard++;
      end
      #1 rst_n = 1'b0;
      if (guard >= 400) begin
         nchk++; nfail++;
         $display("FAIL run: actual %0d retires expected %0d", nret, n);
      end
      chk("R10 fetch after retire", 32'(r10_bad), 0);
      chk("R11 strobe overlap", 32'(r11_bad), 0);
   endtask

   task automatic t_reset();
      clear_mem();
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 ren in reset", {31'd0, imem_ren}, 1);
      start();
      @(negedge clk);
      chk("R1 fetch strobe", {31'd0, imem_ren}, 1);
      chk("R1 fetch address", imem_addr, 32'h0);
      chk("R1 quiet outputs", {29'd0, retire, dmem_ren, dmem_wen}, 0);
      @(negedge clk);
      chk("R2 decode quiet", {28'd0, imem_ren, retire, dmem_ren, dmem_wen}, 0);
      rst_n = 1'b0;
   endtask

   task automatic t_regops();
      clear_mem();
      imem[0]  = e_i(T_ADDI, 0, 1, 5);
      imem[1]  = e_i(T_ADDI, 0, 2, -3);
      imem[2]  = e_r(F_ADD, 1, 2, 3);
      imem[3]  = e_r(F_SUB, 1, 2, 4);
      imem[4]  = e_r(F_SLT, 2, 1, 5);
      imem[5]  = e_r(F_AND, 1, 2, 6);
      imem[6]  = e_r(F_XOR, 1, 2, 7);
      imem[7]  = e_r(F_ADD, 1, 1, 0);
      imem[8]  = e_i(T_SW, 0, 3, 0);
      imem[9]  = e_i(T_SW, 0, 4, 4);
      imem[10] = e_i(T_SW, 0, 5, 8);
      imem[11] = e_i(T_SW, 0, 6, 12);
      imem[12] = e_i(T_SW, 0, 7, 16);
      imem[13] = e_i(T_SW, 0, 0, 20);
      imem[14] = e_i(T_SW, 0, 1, 24);
      run(15);
      chk("R3 add", dmem[0], 32'd2);
      chk("R3 sub", dmem[1], 32'd8);
      chk("R3 slt signed", dmem[2], 32'd1);
      chk("R3 and", dmem[3], 32'd5);
      chk("R3 xor", dmem[4], 32'hFFFFFFF8);
      chk("R3 r0 write discarded", dmem[5], 32'd0);
      chk("R4 addi", dmem[6], 32'd5);
      chk("R3 reg op cycles", 32'(lens[2]), 4);
      chk("R4 imm op cycles", 32'(lens[0]), 4);
      chk("R6 store cycles", 32'(lens[8]), 4);
      chk("R6 store addr 24", dmem[7], 32'hDEADBEEF);
   endtask

   task automatic t_immops();
      clear_mem();
      imem[0] = e_i(T_ORI, 0, 1, 16'h8001);
      imem[1] = e_i(T_LUI, 0, 2, 16'h1234);
      imem[2] = e_i(T_ADDI, 0, 3, 16'h8001);
      imem[3] = e_i(T_ORI, 2, 4, 16'h00FF);
      imem[4] = e_i(T_SW, 0, 1, 0);
      imem[5] = e_i(T_SW, 0, 2, 4);
      imem[6] = e_i(T_SW, 0, 3, 8);
      imem[7] = e_i(T_SW, 0, 4, 12);
      run(8);
      chk("R4 ori zero-extends", dmem[0], 32'h00008001);
      chk("R4 lui", dmem[1], 32'h12340000);
      chk("R4 addi sign-extends", dmem[2], 32'hFFFF8001);
      chk("R4 ori on upper", dmem[3], 32'h123400FF);
      chk("R4 lui cycles", 32'(lens[1]), 4);
   endtask

   task automatic t_loads();
      clear_mem();
      dmem[5] = 32'hCAFEF00D;
      imem[0] = e_i(T_ADDI, 0, 1, 24);
      imem[1] = e_i(T_LW, 1, 2, -4);
      imem[2] = e_i(T_SW, 1, 2, 8);
      imem[3] = e_i(T_LW, 1, 0, -4);
      imem[4] = e_i(T_SW, 1, 0, 12);
      run(5);
      chk("R5 loaded value stored", dmem[8], 32'hCAFEF00D);
      chk("R5 load into r0 discarded", dmem[9], 32'd0);
      chk("R5 source word intact", dmem[5], 32'hCAFEF00D);
      chk("R5 load cycles", 32'(lens[1]), 5);
      chk("R5 load cycles r0", 32'(lens[3]), 5);
      chk("R6 store after load cycles", 32'(lens[2]), 4);
   endtask

   task automatic t_branch();
      clear_mem();
      imem[0] = e_i(T_ADDI, 0, 1, 1);
      imem[1] = e_i(T_BEQZ, 1, 0, 2);
      imem[2] = e_i(T_BEQZ, 0, 0, 2);
      imem[3] = e_i(T_ADDI, 0, 9, 16'h77);
      imem[4] = e_i(T_ADDI, 0, 9, 16'h66);
      imem[5] = e_i(T_SW, 0, 9, 0);
      run(4);
      chk("R7 not-taken next pc", fpc[2], 32'd8);
      chk("R7 taken target", fpc[3], 32'd20);
      chk("R7 skipped code", dmem[0], 32'd0);
      chk("R7 not-taken cycles", 32'(lens[1]), 3);
      chk("R7 taken cycles", 32'(lens[2]), 3);
   endtask

   task automatic t_jumps();
      logic [31:0] exp_pc [10];
      int exp_len [10];
      clear_mem();
      imem[0]  = e_j(T_JAL, 4);
      imem[4]  = e_i(T_SW, 0, 31, 0);
      imem[5]  = e_i(T_ADDI, 0, 5, 40);
      imem[6]  = e_i(T_JALR, 5, 0, 0);
      imem[10] = e_i(T_SW, 0, 31, 4);
      imem[11] = e_i(T_ADDI, 0, 6, 56);
      imem[12] = e_i(T_JR, 6, 0, 0);
      imem[14] = e_j(T_J, 24);
      imem[24] = e_i(T_BEQZ, 0, 0, -22);
      imem[3]  = e_i(T_SW, 0, 6, 8);
      exp_pc  = '{32'd0, 32'd16, 32'd20, 32'd24, 32'd40, 32'd44, 32'd48, 32'd56, 32'd96, 32'd12};
      exp_len = '{3, 4, 4, 3, 4, 4, 3, 3, 3, 4};
      run(10);
      for (int i = 0; i < 10; i++) begin
         chk($sformatf("R8 fetch order %0d", i), fpc[i], exp_pc[i]);
         chk($sformatf("R8 cycles %0d", i), 32'(lens[i]), 32'(exp_len[i]));
      end
      chk("R8 jal link", dmem[0], 32'd4);
      chk("R8 jalr link", dmem[1], 32'd28);
      chk("R7 backward branch reached", dmem[2], 32'd56);
   endtask

   task automatic t_illegal();
      clear_mem();
      imem[0] = e_i(T_ADDI, 0, 2, 9);
      imem[1] = e_r(F_BAD, 2, 2, 1);
      imem[2] = e_i(T_BAD, 2, 1, 5);
      imem[3] = e_i(T_SW, 0, 1, 0);
      run(4);
      chk("R9 no register change", dmem[0], 32'd0);
      chk("R9 bad func cycles", 32'(lens[1]), 3);
      chk("R9 bad opcode cycles", 32'(lens[2]), 3);
      chk("R9 sequential pc", fpc[3], 32'd12);
      chk("R9 no stray write", dmem[1], 32'hDEADBEEF);
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      #(5 * 100000);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      t_reset();
      t_regops();
      t_immops();
      t_loads();
      t_branch();
      t_jumps();
      t_illegal();
      finish_up();
   end
endmodule